// File: doc/BRIEF.md
# Privilege-Aware Interrupt Enable and Priority Selector

This block decides which pending interrupt, if any, a hart takes next. It receives the current privilege mode, the three global interrupt-enable bits (machine, supervisor, user), two delegation words and a pending word. It builds a per-interrupt enable mask from the mode and the delegation settings. It then picks the highest-ranked interrupt that is both pending and enabled, and reports a valid flag and the cause code of that interrupt.

The result is registered once. A trap-entry unit samples `irq_valid` and `irq_cause` one cycle after it presents the inputs. The block has no state machine: the mode input selects which enable rule applies, and a fixed ranking of nine interrupt sources resolves conflicts. The pending, mask and delegation words use cause-number bit positions, so bits 2, 6 and 10 do not belong to any interrupt.

Top module: `irq_select`

## Requirements
- R1: A synchronous active-high `rst` clears `irq_valid` to 0 and `irq_cause` to 0 at the next rising edge of `clk`.
- R2: The outputs are registered. The result for the inputs sampled at one rising edge appears just after that edge and holds until the next edge.
- R3: In user mode (`prv_mode` = 0), each machine-level and supervisor-level interrupt is enabled when its bit in `deleg_s` is 0. When that bit is 1, the interrupt is enabled only if `ena_u` = 1.
- R4: In user mode, the user-level interrupts (causes 0, 4, 8) are enabled only when `ena_u` = 1.
- R5: In supervisor mode (`prv_mode` = 1), each machine-level interrupt is enabled when its bit in `deleg_m` is 0. When that bit is 1, the interrupt is enabled only if `ena_s` = 1.
- R6: In supervisor mode, the supervisor-level interrupts (causes 1, 5, 9) are enabled only when `ena_s` = 1, and the user-level interrupts are never enabled.
- R7: In machine mode (`prv_mode` = 3), the machine-level interrupts (causes 3, 7, 11) are enabled only when `ena_m` = 1, and all supervisor-level and user-level interrupts are masked.
- R8: `prv_mode` = 2 is reserved and yields `irq_valid` = 0.
- R9: Cause codes are: user software 0, supervisor software 1, machine software 3, user timer 4, supervisor timer 5, machine timer 7, user external 8, supervisor external 9, machine external 11. Bit n of the pending word carries cause n. The chosen cause is the first interrupt that is both pending and enabled, in this rank order from highest: 11, 7, 3, 9, 5, 1, 8, 4, 0.
- R10: When no interrupt is both pending and enabled, `irq_valid` = 0 and `irq_cause` = 0.
- R11: Pending bits 2, 6 and 10 are ignored and never produce an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prv_mode | input | 2 | Current privilege: 0 user, 1 supervisor, 2 reserved, 3 machine |
| ena_m | input | 1 | Machine global interrupt enable |
| ena_s | input | 1 | Supervisor global interrupt enable |
| ena_u | input | 1 | User global interrupt enable |
| deleg_m | input | 12 | Machine delegation word, bit n per cause n |
| deleg_s | input | 12 | Supervisor delegation word, bit n per cause n |
| pend | input | 12 | Pending interrupts, bit n per cause n |
| irq_valid | output | 1 | An interrupt was selected |
| irq_cause | output | 4 | Cause code of the selected interrupt |

## Verification
The assertions check, on every cycle, the masking rules that need no knowledge of pending contents:
- the reserved mode stays silent;
- machine mode never reports a lower-level cause;
- supervisor mode never reports a user cause;
- a cleared enable bit suppresses its own level;
- an empty pending word gives nothing;
- every reported cause is one of the nine legal codes.

The delegation effects, the exact rank order between competing interrupts, the reset clearing and the one-cycle latency depend on specific input combinations. Only the bench's vector table and directed cases can show them.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    localparam int IRQ_W   = 12;  // width of pending/mask/delegation words
    localparam int NUM_SRC = 9;   // number of real interrupt sources
    localparam int CAUSE_W = $clog2(IRQ_W);

    typedef enum logic [1:0] {
        PRV_USER  = 2'b00,
        PRV_SUPER = 2'b01,
        PRV_RSVD  = 2'b10,
        PRV_MACH  = 2'b11
    } prv_e;

    typedef enum logic [1:0] {
        LVL_USER,
        LVL_SUPER,
        LVL_MACH,
        LVL_NONE
    } lvl_e;

    // Level owning a given cause bit position.
    function automatic lvl_e level_of(input int unsigned b);
        unique case (b % 4)
            0:       level_of = LVL_USER;
            1:       level_of = LVL_SUPER;
            3:       level_of = LVL_MACH;
            default: level_of = LVL_NONE;
        endcase
    endfunction

    // Cause code held at rank k (rank 0 = highest priority).
    // Ranks walk levels machine, supervisor, user; within a level
    // external, timer, software.
    function automatic int unsigned rank_cause(input int unsigned k);
        int unsigned lvl_off;
        int unsigned kind_off;
        lvl_off  = 3 - (k / 3);          // 3 machine, 2 -> fixed below
        if (lvl_off == 2) lvl_off = 1;   // supervisor offset
        else if (lvl_off == 1) lvl_off = 0; // user offset
        kind_off = 8 - 4 * (k % 3);      // external 8, timer 4, software 0
        rank_cause = kind_off + lvl_off;
    endfunction

endpackage

// File: rtl/irq_enable_mask.sv
module irq_enable_mask
    import irq_sel_pkg::*;
#(
    parameter int W = IRQ_W
) (
    input  logic [1:0]   prv_mode,
    input  logic         ena_m,
    input  logic         ena_s,
    input  logic         ena_u,
    input  logic [W-1:0] deleg_m,
    input  logic [W-1:0] deleg_s,
    output logic [W-1:0] en_mask
);

    prv_e mode;
    assign mode = prv_e'(prv_mode);

    always_comb begin
        en_mask = '0;
        for (int b = 0; b < W; b++) begin
            unique case (mode)
                PRV_USER: begin
                    unique case (level_of(b))
                        LVL_MACH, LVL_SUPER: en_mask[b] = !deleg_s[b] || ena_u;
                        LVL_USER:            en_mask[b] = ena_u;
                        default:             en_mask[b] = 1'b0;
                    endcase
                end
                PRV_SUPER: begin
                    unique case (level_of(b))
                        LVL_MACH:  en_mask[b] = !deleg_m[b] || ena_s;
                        LVL_SUPER: en_mask[b] = ena_s;
                        default:   en_mask[b] = 1'b0;
                    endcase
                end
                PRV_MACH: begin
                    en_mask[b] = (level_of(b) == LVL_MACH) && ena_m;
                end
                default: en_mask[b] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/irq_priority_pick.sv
module irq_priority_pick
    import irq_sel_pkg::*;
#(
    parameter int W   = IRQ_W,
    parameter int N   = NUM_SRC,
    parameter int CW  = CAUSE_W
) (
    input  logic [W-1:0]  qual,
    output logic          hit_any,
    output logic [CW-1:0] hit_cause
);

    logic [N-1:0]  ranked;
    logic [CW-1:0] rank_code [N];

    for (genvar k = 0; k < N; k++) begin : g_rank
        localparam int unsigned CODE = rank_cause(k);
        assign ranked[k]    = qual[CODE];
        assign rank_code[k] = CW'(CODE);
    end

    always_comb begin
        hit_any   = 1'b0;
        hit_cause = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (ranked[k]) begin
                hit_any   = 1'b1;
                hit_cause = rank_code[k];
            end
        end
    end

endmodule

// File: rtl/irq_select.sv
module irq_select
    import irq_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         prv_mode,
    input  logic               ena_m,
    input  logic               ena_s,
    input  logic               ena_u,
    input  logic [IRQ_W-1:0]   deleg_m,
    input  logic [IRQ_W-1:0]   deleg_s,
    input  logic [IRQ_W-1:0]   pend,
    output logic               irq_valid,
    output logic [CAUSE_W-1:0] irq_cause
);

    logic [IRQ_W-1:0]   en_mask;
    logic [IRQ_W-1:0]   qual;
    logic               pick_valid;
    logic [CAUSE_W-1:0] pick_cause;

    irq_enable_mask #(.W(IRQ_W)) i_mask (
        .prv_mode (prv_mode),
        .ena_m    (ena_m),
        .ena_s    (ena_s),
        .ena_u    (ena_u),
        .deleg_m  (deleg_m),
        .deleg_s  (deleg_s),
        .en_mask  (en_mask)
    );

    assign qual = pend & en_mask;

    irq_priority_pick #(.W(IRQ_W), .N(NUM_SRC), .CW(CAUSE_W)) i_pick (
        .qual      (qual),
        .hit_any   (pick_valid),
        .hit_cause (pick_cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_valid <= 1'b0;
            irq_cause <= '0;
        end else begin
            irq_valid <= pick_valid;
            irq_cause <= pick_valid ? pick_cause : '0;
        end
    end

    AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irq_cause inside {4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd7, 4'd8, 4'd9, 4'd11})); // R9
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (rst)
        (prv_mode == 2'b10) |=> !irq_valid); // R8
    AST_MACH_LOWER_MASKED: assert property (@(posedge clk) disable iff (rst)
        (prv_mode == 2'b11) |=> (!irq_valid || (irq_cause inside {4'd3, 4'd7, 4'd11}))); // R7
    AST_MACH_MIE_OFF: assert property (@(posedge clk) disable iff (rst)
        (prv_mode == 2'b11 && !ena_m) |=> !irq_valid); // R7
    AST_SUPER_USER_MASKED: assert property (@(posedge clk) disable iff (rst)
        (prv_mode == 2'b01) |=> (!irq_valid || !(irq_cause inside {4'd0, 4'd4, 4'd8}))); // R6
    AST_SUPER_SIE_OFF: assert property (@(posedge clk) disable iff (rst)
        (prv_mode == 2'b01 && !ena_s) |=> (!irq_valid || (irq_cause inside {4'd3, 4'd7, 4'd11}))); // R6
    AST_USER_UIE_OFF: assert property (@(posedge clk) disable iff (rst)
        (prv_mode == 2'b00 && !ena_u) |=> (!irq_valid || !(irq_cause inside {4'd0, 4'd4, 4'd8}))); // R4
    AST_NONE_PENDING: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |=> (!irq_valid && irq_cause == '0)); // R10

endmodule

// File: tb/test_irq_select.sv
module test_irq_select;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  prv_mode;
    logic        ena_m, ena_s, ena_u;
    logic [11:0] deleg_m, deleg_s, pend;
    logic        irq_valid;
    logic [3:0]  irq_cause;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    irq_select i_irq_select (
        .clk(clk), .rst(rst), .prv_mode(prv_mode),
        .ena_m(ena_m), .ena_s(ena_s), .ena_u(ena_u),
        .deleg_m(deleg_m), .deleg_s(deleg_s), .pend(pend),
        .irq_valid(irq_valid), .irq_cause(irq_cause)
    );

    // {req[4], mode[2], mie, sie, uie, deleg_m[12], deleg_s[12], pend[12], exp_valid, exp_cause[4]}
    localparam int NV = 26;
    localparam logic [49:0] VEC [NV] = '{
        {4'd9,  2'd3, 3'b100, 12'h000, 12'h000, 12'hBBB, 1'b1, 4'd11}, // R9 machine, all pending
        {4'd9,  2'd3, 3'b100, 12'h000, 12'h000, 12'h088, 1'b1, 4'd7},  // R9 timer over software
        {4'd7,  2'd3, 3'b011, 12'h000, 12'h000, 12'hBBB, 1'b0, 4'd0},  // R7 mie off
        {4'd7,  2'd3, 3'b111, 12'h000, 12'h000, 12'h333, 1'b0, 4'd0},  // R7 lower levels masked
        {4'd6,  2'd1, 3'b010, 12'h000, 12'h000, 12'h222, 1'b1, 4'd9},  // R6 supervisor external
        {4'd6,  2'd1, 3'b010, 12'h000, 12'h000, 12'h022, 1'b1, 4'd5},  // R6 supervisor timer
        {4'd5,  2'd1, 3'b000, 12'h000, 12'h000, 12'h800, 1'b1, 4'd11}, // R5 not delegated
        {4'd5,  2'd1, 3'b000, 12'h800, 12'h000, 12'h800, 1'b0, 4'd0},  // R5 delegated, sie off
        {4'd5,  2'd1, 3'b010, 12'h800, 12'h000, 12'h800, 1'b1, 4'd11}, // R5 delegated, sie on
        {4'd6,  2'd1, 3'b111, 12'h000, 12'h000, 12'h111, 1'b0, 4'd0},  // R6 user masked
        {4'd6,  2'd1, 3'b101, 12'h000, 12'h000, 12'h222, 1'b0, 4'd0},  // R6 sie off
        {4'd3,  2'd0, 3'b000, 12'h000, 12'h000, 12'h008, 1'b1, 4'd3},  // R3 not delegated
        {4'd3,  2'd0, 3'b000, 12'h000, 12'h008, 12'h008, 1'b0, 4'd0},  // R3 delegated, uie off
        {4'd3,  2'd0, 3'b001, 12'h000, 12'h008, 12'h008, 1'b1, 4'd3},  // R3 delegated, uie on
        {4'd3,  2'd0, 3'b000, 12'h000, 12'h000, 12'h020, 1'b1, 4'd5},  // R3 supervisor level in user
        {4'd3,  2'd0, 3'b000, 12'hFFF, 12'h000, 12'h800, 1'b1, 4'd11}, // R3 deleg_m has no effect
        {4'd4,  2'd0, 3'b110, 12'h000, 12'h000, 12'h111, 1'b0, 4'd0},  // R4 uie off
        {4'd4,  2'd0, 3'b001, 12'h000, 12'h000, 12'h111, 1'b1, 4'd8},  // R4 user external
        {4'd4,  2'd0, 3'b001, 12'h000, 12'h000, 12'h011, 1'b1, 4'd4},  // R4 user timer
        {4'd4,  2'd0, 3'b001, 12'h000, 12'h000, 12'h001, 1'b1, 4'd0},  // R4 user software
        {4'd8,  2'd2, 3'b111, 12'h000, 12'h000, 12'hBBB, 1'b0, 4'd0},  // R8 reserved mode
        {4'd11, 2'd3, 3'b111, 12'h000, 12'h000, 12'h444, 1'b0, 4'd0},  // R11 reserved bits
        {4'd11, 2'd0, 3'b000, 12'h000, 12'h000, 12'h446, 1'b1, 4'd1},  // R11 reserved bits beside SSI
        {4'd9,  2'd0, 3'b000, 12'h000, 12'h800, 12'h880, 1'b1, 4'd7},  // R9 delegated MEI skipped
        {4'd9,  2'd0, 3'b001, 12'h000, 12'h000, 12'h801, 1'b1, 4'd11}, // R9 rank, not index
        {4'd9,  2'd1, 3'b010, 12'h000, 12'h000, 12'h208, 1'b1, 4'd3}   // R9 MSI over SEI
    };

    task automatic check(input int req, input logic ev, input logic [3:0] ec);
        n_chk++;
        if (irq_valid !== ev || irq_cause !== ec) begin
            n_fail++;
            $display("FAIL R%0d: got valid=%0b cause=%0d, expected valid=%0b cause=%0d",
                     req, irq_valid, irq_cause, ev, ec);
        end
    endtask

    task automatic apply(input logic [49:0] v);
        prv_mode = v[45:44];
        ena_m    = v[43];
        ena_s    = v[42];
        ena_u    = v[41];
        deleg_m  = v[40:29];
        deleg_s  = v[28:17];
        pend     = v[16:5];
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        apply({4'd0, 2'd3, 3'b111, 12'h000, 12'h000, 12'hBBB, 5'd0});
        repeat (2) @(posedge clk);
        @(negedge clk);
        check(1, 1'b0, 4'd0);  // R1 reset state despite pending
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            @(posedge clk);
            @(negedge clk);
            check(int'(VEC[i][49:46]), VEC[i][4], VEC[i][3:0]);
        end

        // R2: output holds until the next edge, then follows
        apply({4'd0, 2'd3, 3'b100, 12'h000, 12'h000, 12'h800, 5'd0});
        @(posedge clk); @(negedge clk);
        pend = 12'h000;
        #1;
        check(2, 1'b1, 4'd11);
        @(posedge clk); @(negedge clk);
        check(2, 1'b0, 4'd0);

        // R1: reset during activity
        pend = 12'h080;
        @(posedge clk); @(negedge clk);
        check(2, 1'b1, 4'd7);
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check(1, 1'b0, 4'd0);
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(1, 1'b1, 4'd7);

        // R10: nothing pending in any mode
        pend = 12'h000;
        for (int m = 0; m < 4; m++) begin
            prv_mode = 2'(m);
            ena_m = 1'b1; ena_s = 1'b1; ena_u = 1'b1;
            @(posedge clk); @(negedge clk);
            check(10, 1'b0, 4'd0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule